// File: doc/BRIEF.md
# EDO DRAM Access Cycle Controller

This block sits between an on-chip requester and a 32-bit bank of extended-data-out DRAM. The requester offers a word address, byte enables, write data and a direction flag through a valid/ready handshake. The controller turns each accepted request into row-strobe, column-strobe and write-enable sequences on ten multiplexed address lines. Every minimum time in the DRAM's timing table is given in nanoseconds as a parameter. The controller converts each one to a count of system clocks by rounding up, so one parameter set describes one speed grade.

The controller keeps a row open after an access. A later request to the same row runs as a page cycle: one more column strobe, with no new row activation. A request to another row, a refresh grant from an outside arbiter, or the approach of the page-mode limit on how long the row strobe may stay low makes the controller precharge the row first. Writes are always early writes: the write enable falls together with the column strobes and the data bus is driven from that edge. The controller samples read data one clock after the column access time has run out and returns it with a one-cycle valid pulse.

Top module: `edo_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycles after it is released, the row strobe, all four column strobes and the write enable are high, the data bus is not driven and `rsp_valid` is low.
- R2: The address is split into row `req_addr[19:10]` and column `req_addr[9:0]`. The row appears on `dram_addr` when the row strobe falls, and the column appears when the column strobes fall.
- R3: `dram_cas_n[i]` strobes data bits `8*i+7 .. 8*i`. A write pulls low only the strobes whose `req_be` bit is 1, so the other bytes keep their contents. A read pulls all four low.
- R4: For a write, `dram_we_n` falls at the same edge as the column strobes, and the data bus is driven whenever `dram_we_n` is low. For a read, `dram_we_n` stays high.
- R5: Read data is sampled max(ceil(tCAS), ceil(tCAC)+1) clocks after the column strobes fall. It appears with a one-cycle `rsp_valid` pulse in the next cycle, and responses come back in request order.
- R6: A request to the open row runs without a new row-strobe fall. Successive column-strobe falls are at least ceil(tHPC) clocks apart, and the strobes stay high for at least ceil(tCP) clocks between them.
- R7: A request to a different row precharges and reopens the row. The row strobe stays low for at least ceil(tRAS) clocks and high for at least max(ceil(tRP), ceil(tRC)-ceil(tRAS)) clocks. The column strobes fall at least ceil(tRCD) clocks after the row strobe.
- R8: The row strobe never stays low longer than ceil(tRASP) clocks. An open row is closed on time even when no requests arrive, and a long same-row stream is split into several row activations.
- R9: While `ref_grant` is high, `req_ready` is low and any open row is closed once its minimum low time has been met.
- R10: A request is taken only in a cycle where both `req_valid` and `req_ready` are high. A request offered while ready is low causes no strobe activity and no write.
- R11: No column strobe is ever low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper 10 bits |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 32 | Read data |
| ref_grant | input | 1 | Refresh owns the DRAM; close the row and hold off |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Per-byte column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_oe | output | 1 | Drive the data bus |
| dram_dq_out | output | 32 | Write data to the bus |
| dram_dq_in | input | 32 | Data from the bus |

## Verification
The refresh grant and a page hit can fall in the same cycle. A same-row write is pending on an open row when the grant rises. The bench sets up exactly that case: it raises `ref_grant` while a hitting write is held valid. The grant must win: ready stays low, the row strobe rises, no column strobe falls, and a later read of that word returns its old contents.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_OPEN,
    ST_PRE
  } edo_state_e;

  // Minimum time in ns to whole clocks, rounded up
  function automatic int unsigned ns2clk(int unsigned t_ns, int unsigned per_ns);
    return (t_ns + per_ns - 1) / per_ns;
  endfunction

endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // the current cycle completes the loaded interval
  assign last = (cnt_q <= W'(1));
endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RAS_C  = 5,
  parameter int unsigned LIMIT  = 100,
  parameter int unsigned SAT    = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_low,
  input  logic             open_en,
  input  logic [ROW_W-1:0] open_row,
  input  logic [ROW_W-1:0] req_row,
  output logic             hit,
  output logic             min_met,
  output logic             limit_hit
);
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] low_q, low_d;
  logic             low_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (open_en) row_q <= open_row;
  end

  always_comb begin
    low_en = 1'b1;
    low_d  = '0;
    if (ras_low) begin
      low_en = (low_q != CNT_W'(SAT));
      low_d  = low_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_q <= '0;
    else if (low_en) low_q <= low_d;
  end

  assign hit       = (req_row == row_q);
  assign min_met   = (low_q >= CNT_W'(RAS_C - 1));
  assign limit_hit = (low_q >= CNT_W'(LIMIT));
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl import edo_pkg::*; #(
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned T_RC_NS     = 90,
  parameter int unsigned T_RAS_NS    = 50,
  parameter int unsigned T_RP_NS     = 30,
  parameter int unsigned T_CAS_NS    = 8,
  parameter int unsigned T_RCD_NS    = 20,
  parameter int unsigned T_HPC_NS    = 25,
  parameter int unsigned T_CP_NS     = 8,
  parameter int unsigned T_CAC_NS    = 15,
  parameter int unsigned T_RASP_NS   = 200000,
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned COL_W       = 10,
  parameter int unsigned DATA_W      = 32,
  localparam int unsigned BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ref_grant,
  output logic [COL_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic [BE_W-1:0]   dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_dq_oe,
  output logic [DATA_W-1:0] dram_dq_out,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int unsigned ROW_W  = ADDR_W - COL_W;
  localparam int unsigned RC_C   = ns2clk(T_RC_NS, CLK_NS);
  localparam int unsigned RAS_C  = ns2clk(T_RAS_NS, CLK_NS);
  localparam int unsigned RP_C   = ns2clk(T_RP_NS, CLK_NS);
  localparam int unsigned CAS_C  = ns2clk(T_CAS_NS, CLK_NS);
  localparam int unsigned RCD_C  = ns2clk(T_RCD_NS, CLK_NS);
  localparam int unsigned HPC_C  = ns2clk(T_HPC_NS, CLK_NS);
  localparam int unsigned CP_C   = ns2clk(T_CP_NS, CLK_NS);
  localparam int unsigned CAC_C  = ns2clk(T_CAC_NS, CLK_NS);
  localparam int unsigned RASP_C = ns2clk(T_RASP_NS, CLK_NS);
  localparam int unsigned PRE_C  = (RC_C > RAS_C + RP_C) ? RC_C - RAS_C : RP_C;
  localparam int unsigned RD_C   = (CAS_C > CAC_C + 1) ? CAS_C : CAC_C + 1;
  localparam int unsigned WR_C   = CAS_C;
  localparam int unsigned SLACK  = RD_C + CP_C + 1;
  localparam int unsigned LIMIT  = (RASP_C > SLACK) ? RASP_C - SLACK : 1;
  localparam int unsigned TW     = $clog2(RC_C + HPC_C + RD_C + PRE_C + RCD_C + CP_C + 4);
  localparam int unsigned RW     = $clog2(RASP_C + 2);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  edo_state_e        state_q, state_d;
  logic              ras_n_q, ras_n_d, we_n_q, we_n_d, oe_q, oe_d;
  logic [BE_W-1:0]   cas_n_q, cas_n_d;
  logic [COL_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0] dout_q, dout_d, rsp_d_q, rsp_d_d;
  logic              rsp_v_q, rsp_v_d;
  logic              wr_q;
  logic [BE_W-1:0]   be_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q;
  logic              latch_en, col_go, row_open_en;
  logic              tmr_load, tmr_last, hpc_load, hpc_last;
  logic [TW-1:0]     tmr_val;
  logic              row_hit, ras_min, limit_hit;
  logic              idle_ok, page_ok, accept, close_req;
  logic              src_wr;
  logic [BE_W-1:0]   src_be;
  logic [COL_W-1:0]  src_col;
  logic [DATA_W-1:0] src_wd;
  logic [ROW_W-1:0]  req_row;

  assign req_row = req_addr[ADDR_W-1:COL_W];

  edo_timer #(.W(TW)) u_state_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .load_val(tmr_val), .last(tmr_last));

  edo_timer #(.W(TW)) u_page_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(hpc_load), .load_val(TW'(HPC_C)), .last(hpc_last));

  edo_row_track #(.ROW_W(ROW_W), .CNT_W(RW), .RAS_C(RAS_C), .LIMIT(LIMIT), .SAT(RASP_C)) u_row (
    .clk(clk), .rst_n(rst_n_s), .ras_low(!ras_n_q), .open_en(row_open_en),
    .open_row(req_row), .req_row(req_row), .hit(row_hit), .min_met(ras_min),
    .limit_hit(limit_hit));

  assign idle_ok   = (state_q == ST_IDLE) && tmr_last && !ref_grant;
  assign page_ok   = (state_q == ST_OPEN) && tmr_last && hpc_last && !ref_grant &&
                     row_hit && !limit_hit;
  assign req_ready = idle_ok || page_ok;
  assign accept    = req_valid && req_ready;
  assign close_req = ref_grant || limit_hit || (req_valid && !row_hit);

  // a page hit starts the column cycle from the live request
  assign src_wr  = (state_q == ST_OPEN) ? req_write : wr_q;
  assign src_be  = (state_q == ST_OPEN) ? req_be : be_q;
  assign src_col = (state_q == ST_OPEN) ? req_addr[COL_W-1:0] : col_q;
  assign src_wd  = (state_q == ST_OPEN) ? req_wdata : wd_q;

  always_comb begin
    state_d     = state_q;
    ras_n_d     = ras_n_q;
    cas_n_d     = cas_n_q;
    we_n_d      = we_n_q;
    oe_d        = oe_q;
    addr_d      = addr_q;
    dout_d      = dout_q;
    rsp_v_d     = 1'b0;
    rsp_d_d     = rsp_d_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    hpc_load    = 1'b0;
    col_go      = 1'b0;
    latch_en    = 1'b0;
    row_open_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d     = ST_ROW;
        ras_n_d     = 1'b0;
        addr_d      = req_row;
        tmr_load    = 1'b1;
        tmr_val     = TW'(RCD_C);
        latch_en    = 1'b1;
        row_open_en = 1'b1;
      end
      ST_ROW: col_go = tmr_last;
      ST_COL: if (tmr_last) begin
        state_d  = ST_OPEN;
        cas_n_d  = '1;
        we_n_d   = 1'b1;
        oe_d     = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = TW'(CP_C);
        if (!wr_q) begin
          rsp_v_d = 1'b1;
          rsp_d_d = dram_dq_in;
        end
      end
      ST_OPEN: begin
        if (accept) begin
          latch_en = 1'b1;
          col_go   = 1'b1;
        end else if (close_req && ras_min) begin
          state_d  = ST_PRE;
          ras_n_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(PRE_C);
        end
      end
      ST_PRE: if (tmr_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (col_go) begin
      state_d  = ST_COL;
      cas_n_d  = src_wr ? ~src_be : '0;
      we_n_d   = !src_wr;
      oe_d     = src_wr;
      dout_d   = src_wd;
      addr_d   = src_col;
      tmr_load = 1'b1;
      tmr_val  = src_wr ? TW'(WR_C) : TW'(RD_C);
      hpc_load = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      ras_n_q <= 1'b1;
      cas_n_q <= '1;
      we_n_q  <= 1'b1;
      oe_q    <= 1'b0;
      addr_q  <= '0;
      dout_q  <= '0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      state_q <= state_d;
      ras_n_q <= ras_n_d;
      cas_n_q <= cas_n_d;
      we_n_q  <= we_n_d;
      oe_q    <= oe_d;
      addr_q  <= addr_d;
      dout_q  <= dout_d;
      rsp_v_q <= rsp_v_d;
      rsp_d_q <= rsp_d_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_q  <= 1'b0;
      be_q  <= '0;
      col_q <= '0;
      wd_q  <= '0;
    end else if (latch_en) begin
      wr_q  <= req_write;
      be_q  <= req_be;
      col_q <= req_addr[COL_W-1:0];
      wd_q  <= req_wdata;
    end
  end

  assign dram_ras_n  = ras_n_q;
  assign dram_cas_n  = cas_n_q;
  assign dram_we_n   = we_n_q;
  assign dram_dq_oe  = oe_q;
  assign dram_addr   = addr_q;
  assign dram_dq_out = dout_q;
  assign rsp_valid   = rsp_v_q;
  assign rsp_rdata   = rsp_d_q;
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int unsigned RP_C   = 3,
  parameter int unsigned RCD_C  = 2,
  parameter int unsigned RASP_C = 20000,
  parameter int unsigned BE_W   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic [BE_W-1:0] cas_n,
  input logic            we_n,
  input logic            dq_oe,
  input logic            req_valid,
  input logic            req_ready,
  input logic            ref_grant
);
  localparam int unsigned LW = $clog2(RASP_C + 2);
  localparam int unsigned HW = $clog2(RP_C + RCD_C + 2);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (ras_n)                      low_cnt <= '0;
    else if (low_cnt != LW'(RASP_C + 1)) low_cnt <= low_cnt + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        high_cnt <= HW'(RP_C);
    else if (!ras_n)                   high_cnt <= '0;
    else if (high_cnt != HW'(RP_C))    high_cnt <= high_cnt + HW'(1);
  end

  assert_cas_under_ras_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1) |-> !ras_n);

  assert_write_drives_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  assert_ras_low_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (low_cnt < LW'(RASP_C)));

  assert_precharge_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_cnt >= HW'(RP_C)));

  assert_ras_to_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> (cas_n == '1));

  assert_grant_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> !req_ready);

  assert_accept_opens_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !ras_n);
endmodule

bind edo_ctrl edo_ctrl_chk #(.RP_C(RP_C), .RCD_C(RCD_C), .RASP_C(RASP_C), .BE_W(BE_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .dq_oe(dram_dq_oe), .req_valid(req_valid), .req_ready(req_ready), .ref_grant(ref_grant));

// File: tb/edo_ctrl_test.sv
module edo_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int T_RC = 90, T_RAS = 50, T_RP = 30, T_CAS = 8, T_RCD = 20;
  localparam int T_HPC = 25, T_CP = 8, T_CAC = 15, T_RASP = 600;
  localparam int RC_C   = (T_RC + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RAS_C  = (T_RAS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RP_C   = (T_RP + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int CAS_C  = (T_CAS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RCD_C  = (T_RCD + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int HPC_C  = (T_HPC + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int CP_C   = (T_CP + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int CAC_C  = (T_CAC + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RASP_C = (T_RASP + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int HIGH_C = (RP_C > RC_C - RAS_C) ? RP_C : RC_C - RAS_C;
  localparam int RDLAT  = (CAS_C > CAC_C + 1) ? CAS_C : CAC_C + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_grant = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] dram_dq_in = '0;
  logic req_ready, rsp_valid, dram_ras_n, dram_we_n, dram_dq_oe;
  logic [31:0] rsp_rdata, dram_dq_out;
  logic [9:0]  dram_addr;
  logic [3:0]  dram_cas_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  edo_ctrl #(.CLK_NS(CLK_PERIOD), .T_RASP_NS(T_RASP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_grant(ref_grant),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_oe(dram_dq_oe), .dram_dq_out(dram_dq_out),
    .dram_dq_in(dram_dq_in));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // DRAM model and pin monitor
  logic [31:0] mem [0:1023];
  logic [31:0] shadow [0:1023];
  logic [31:0] exp_q [$];
  logic [9:0]  row_lat = '0, col_lat = '0;
  logic        we_at_cas = 1'b1, prev_ras = 1'b1, first_cas = 1'b0, seen_rise = 1'b0;
  logic [3:0]  prev_cas = 4'hF, falls;
  logic [31:0] rd_v;
  int cyc = 0, ras_falls = 0, cas_falls = 0, lo_run = 0, hi_run = 0;
  int min_lo = 1000000, min_hi = 1000000, max_lo = 0, min_rcd = 1000000;
  int min_per = 1000000, min_cp = 1000000, cas_hi_run = 0;
  int ras_fall_cyc = 0, last_cas_cyc = 0, rd_cas_cyc = 0, viol_cas = 0, viol_we = 0;

  function automatic int idx(input logic [9:0] r, input logic [9:0] c);
    return {r[4:0], c[4:0]};
  endfunction

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (prev_ras && !dram_ras_n) begin
      ras_falls++;
      row_lat = dram_addr;
      if (seen_rise && hi_run < min_hi) min_hi = hi_run;
      hi_run = 0;
      ras_fall_cyc = cyc;
      first_cas = 1'b1;
    end
    if (!prev_ras && dram_ras_n) begin
      if (lo_run < min_lo) min_lo = lo_run;
      lo_run = 0;
      seen_rise = 1'b1;
    end
    if (dram_ras_n) hi_run++;
    else begin
      lo_run++;
      if (lo_run > max_lo) max_lo = lo_run;
    end
    falls = prev_cas & ~dram_cas_n;
    if (|falls) begin
      cas_falls++;
      if (first_cas) begin
        if (cyc - ras_fall_cyc < min_rcd) min_rcd = cyc - ras_fall_cyc;
      end else begin
        if (cyc - last_cas_cyc < min_per) min_per = cyc - last_cas_cyc;
        if (cas_hi_run < min_cp) min_cp = cas_hi_run;
      end
      first_cas = 1'b0;
      last_cas_cyc = cyc;
      col_lat = dram_addr;
      we_at_cas = dram_we_n;
      if (!dram_we_n) begin
        for (int i = 0; i < 4; i++)
          if (falls[i]) mem[idx(row_lat, dram_addr)][8*i +: 8] = dram_dq_out[8*i +: 8];
      end else begin
        dram_dq_in = 32'hDEADBEEF;
        rd_v = mem[idx(row_lat, dram_addr)];
        rd_cas_cyc = cyc;
        fork
          begin
            #(T_CAC - CLK_PERIOD / 2);
            dram_dq_in = rd_v;
          end
        join_none
      end
    end
    if (dram_cas_n == 4'hF) cas_hi_run++;
    else cas_hi_run = 0;
    if (dram_cas_n != 4'hF && dram_ras_n) viol_cas++;
    if (!dram_we_n && !dram_dq_oe) viol_we++;
    // scoreboard monitor
    if (rsp_valid) begin
      chk(cyc - rd_cas_cyc == RDLAT, "R5 latency", cyc - rd_cas_cyc, RDLAT);
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected response", rsp_rdata, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R5 R3 read data", rsp_rdata, e);
      end
    end
    prev_ras = dram_ras_n;
    prev_cas = dram_cas_n;
  end

  function automatic logic [19:0] mk(input int r, input int c);
    return {10'(r), 10'(c)};
  endfunction

  task automatic issue(input bit wr, input logic [19:0] a, input logic [3:0] be, input logic [31:0] d);
    bit acc = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    while (!acc) begin
      #1;
      acc = req_ready;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (wr) begin
      for (int i = 0; i < 4; i++)
        if (be[i]) shadow[idx(a[19:10], a[9:0])][8*i +: 8] = d[8*i +: 8];
    end else exp_q.push_back(shadow[idx(a[19:10], a[9:0])]);
  endtask

  task automatic wr(input logic [19:0] a, input logic [3:0] be, input logic [31:0] d);
    issue(1'b1, a, be, d);
  endtask

  task automatic rd(input logic [19:0] a);
    issue(1'b0, a, 4'h0, 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int rf, cf;
  bit timed_out = 1'b0;

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
    fork
      begin
        idle(5);
        // R1 reset state
        chk(dram_ras_n == 1'b1, "R1 ras", dram_ras_n, 1);
        chk(dram_cas_n == 4'hF, "R1 cas", dram_cas_n, 4'hF);
        rst_n = 1'b1;
        idle(1);
        #1;
        chk(dram_we_n == 1'b1, "R1 we", dram_we_n, 1);
        chk(dram_dq_oe == 1'b0, "R1 oe", dram_dq_oe, 0);
        chk(rsp_valid == 1'b0, "R1 rsp", rsp_valid, 0);
        idle(3);
        // R2 / R4 address mux and early write
        wr(mk(5, 9), 4'hF, 32'h12345678);
        idle(4);
        chk(row_lat == 10'd5, "R2 row", row_lat, 5);
        chk(col_lat == 10'd9, "R2 col", col_lat, 9);
        chk(we_at_cas == 1'b0, "R4 write we", we_at_cas, 0);
        rd(mk(5, 9));
        idle(6);
        chk(we_at_cas == 1'b1, "R4 read we", we_at_cas, 1);
        // R3 byte lanes
        wr(mk(6, 1), 4'hF, 32'hAABBCCDD);
        wr(mk(6, 1), 4'b0101, 32'h11223344);
        rd(mk(6, 1));
        wr(mk(6, 2), 4'hF, 32'h01020304);
        wr(mk(6, 2), 4'b1000, 32'h55667788);
        rd(mk(6, 2));
        idle(10);
        // R6 page hits in a new row
        rf = ras_falls;
        for (int c = 0; c < 4; c++) wr(mk(7, c), 4'hF, 32'hC0DE0000 + 32'(c));
        for (int c = 0; c < 4; c++) rd(mk(7, c));
        idle(10);
        chk(ras_falls - rf == 1, "R6 one activation", ras_falls - rf, 1);
        // R7 row misses
        rf = ras_falls;
        rd(mk(5, 9));
        rd(mk(6, 1));
        idle(10);
        chk(ras_falls - rf == 2, "R7 reactivation", ras_falls - rf, 2);
        // R9 / R10 grant collides with a page hit
        @(negedge clk);
        cf = cas_falls;
        ref_grant = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = mk(6, 3);
        req_be = 4'hF; req_wdata = 32'hBAD0BAD0;
        #1;
        chk(req_ready == 1'b0, "R9 ready low", req_ready, 0);
        idle(12);
        chk(dram_ras_n == 1'b1, "R9 row closed", dram_ras_n, 1);
        chk(cas_falls == cf, "R10 no strobe", cas_falls - cf, 0);
        req_valid = 1'b0;
        ref_grant = 1'b0;
        rd(mk(6, 3));
        idle(10);
        // R8 page limit with no traffic, then a long stream
        rf = ras_falls;
        wr(mk(8, 0), 4'hF, 32'hFACE0008);
        idle(RASP_C + 20);
        chk(dram_ras_n == 1'b1, "R8 idle close", dram_ras_n, 1);
        chk(ras_falls - rf == 1, "R8 one activation", ras_falls - rf, 1);
        rf = ras_falls;
        for (int k = 0; k < 30; k++) rd(mk(8, 0));
        idle(20);
        chk(ras_falls - rf >= 2, "R8 stream split", ras_falls - rf, 2);
        // timing summary
        chk(exp_q.size() == 0, "R5 all returned", exp_q.size(), 0);
        chk(min_lo >= RAS_C, "R7 ras low min", min_lo, RAS_C);
        chk(min_hi >= HIGH_C, "R7 precharge min", min_hi, HIGH_C);
        chk(min_rcd >= RCD_C, "R7 ras to cas", min_rcd, RCD_C);
        chk(min_per >= HPC_C, "R6 page period", min_per, HPC_C);
        chk(min_cp >= CP_C, "R6 cas precharge", min_cp, CP_C);
        chk(max_lo <= RASP_C, "R8 ras low max", max_lo, RASP_C);
        chk(viol_cas == 0, "R11 cas under ras", viol_cas, 0);
        chk(viol_we == 0, "R4 we with bus", viol_we, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule